// File: doc/BRIEF.md
# Byte-wide SPI shifter with shared-pin bidirectional routing

This block moves one byte at a time over a serial peripheral link, either as the master that generates the serial clock or as a slave that follows one. Software sets up the link through a small register port: a control register holds the bit-order, single-wire and halt-in-wait bits, and a data register is written to load the next byte and read to collect the received one. The port has no stall: each strobe completes in its cycle. A data write that arrives while a master transfer is running is dropped, and this is the only back-pressure the port applies.

For each of the four serial pins (MISO, MOSI, SCK, SS) the block produces a drive value and an output enable, and it chooses which pin it samples as receive data. These choices depend on the direction bit for each pin, the master-select input, the SS-output-enable input and the single-wire bit. In single-wire mode the master sends and receives on MOSI and the slave does both on MISO, so one data wire carries traffic in both directions. The clock idles low. Data changes on falling SCK edges and is sampled on rising edges. The SCK half period in master mode is `HALF_PERIOD` system clocks.

Top module: `spi_bidir_byte`

## Requirements
- R1: After reset the control register reads 0, `xfer_done` is 0, SCK drives 0 and SS drives 1.
- R2: Address 0 is control, with bit 0 single-wire, bit 1 halt-in-wait and bit 2 LSB-first. It can be written and read back at any time, and its upper bits read 0. Address 1 is the data register.
- R3: A data write with `master_sel`=1 while idle starts a transfer. The first rising SCK edge follows `HALF_PERIOD` clocks after the write and each later SCK level lasts `HALF_PERIOD` clocks, for eight pulses. SCK is low whenever no transfer runs. SS drives 0 while the transfer runs and 1 otherwise.
- R4: With LSB-first at 0 the byte leaves MSB first, and with it at 1 LSB first. In both cases the received byte reads back with its MSB in bit 7.
- R5: `xfer_done` rises on the clock after the eighth bit is sampled. A read or write of address 1 clears it.
- R6: In normal mode the master drives MOSI and samples MISO. The MOSI enable is `pin_dir[1]` AND master, and the SCK enable is `pin_dir[2]` AND master.
- R7: In single-wire master mode the master samples MOSI, and MISO is neither driven nor used.
- R8: In normal mode the slave samples MOSI and drives MISO. The MISO enable is `pin_dir[0]` AND NOT master AND SS pin low.
- R9: In single-wire slave mode the slave samples MISO, and MOSI is neither driven nor used.
- R10: The SS enable is `pin_dir[3]` AND `ss_out_en` AND master.
- R11: With halt-in-wait at 1, SCK generation freezes while `wait_mode` is 1 and then resumes where it stopped. With the bit at 0, `wait_mode` has no effect.
- R12: A data write during a running master transfer is ignored. Both the bits on the wire and the received byte are unchanged.
- R13: While SCK is high the transmitted data bit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only the data register has a read side effect) |
| reg_addr | input | 1 | 0 control, 1 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| master_sel | input | 1 | 1 master, 0 slave |
| ss_out_en | input | 1 | Lets the master drive SS |
| pin_dir | input | 4 | Direction bits: 0 MISO, 1 MOSI, 2 SCK, 3 SS |
| wait_mode | input | 1 | System wait state |
| pin_in | input | 4 | Pin levels, same index order |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |
| xfer_done | output | 1 | Byte-complete flag |

## Verification
A behavioural model predicts SCK, SS, MOSI, the done flag and all four enables on every clock. Under this model a wrong half-period count or a dropped pulse shows up at once as a wire mismatch, and a swapped bit order sends a mirrored byte. The bench mirrors MOSI back into MOSI in single-wire master mode and drives a different byte on MISO. A design that still sampled MISO would then return that other byte. A mid-transfer data write and a wait-mode freeze are applied during live transfers, so a design that restarted or kept clocking would drift from the model. The enables are swept over every pin-direction, master, SS-output and SS-level combination, which catches a slave that drives MISO while deselected.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int NPINS    = 4;
  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;

  typedef struct packed {
    logic lsb_first;
    logic halt_in_wait;
    logic one_wire;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sbb_clkgen.sv
module sbb_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!hold)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run & ~hold & (cnt == LAST);

  // R11: a held divider does not advance
  p_hold_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(hold) && run) |-> $stable(cnt));
endmodule

// File: rtl/sbb_pinmux.sv
module sbb_pinmux import sbb_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             one_wire,
  input  logic             master,
  input  logic             ss_out_en,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] pin_raw,
  input  logic [NPINS-1:0] pin_sync,
  input  logic             data_bit,
  input  logic             sck_q,
  input  logic             busy,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic             din
);
  logic m_in, s_in;

  always_comb begin
    m_in = one_wire ? pin_raw[PIN_MOSI]  : pin_raw[PIN_MISO];
    s_in = one_wire ? pin_sync[PIN_MISO] : pin_sync[PIN_MOSI];
    din  = master ? m_in : s_in;

    pin_oe[PIN_MISO] = dir[PIN_MISO] & ~master & ~pin_raw[PIN_SS];
    pin_oe[PIN_MOSI] = dir[PIN_MOSI] & master;
    pin_oe[PIN_SCK]  = dir[PIN_SCK]  & master;
    pin_oe[PIN_SS]   = dir[PIN_SS]   & master & ss_out_en;

    pin_out[PIN_MISO] = data_bit;
    pin_out[PIN_MOSI] = data_bit;
    pin_out[PIN_SCK]  = sck_q;
    pin_out[PIN_SS]   = ~busy;
  end

  // R6: in normal mode the master never drives the pin it samples
  p_master_no_self_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_wire && master) |-> !pin_oe[PIN_MISO]);
  // R8: in normal mode the slave never drives the pin it samples
  p_slave_no_self_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_wire && !master) |-> !pin_oe[PIN_MOSI]);
  // R9: single-wire slave leaves MOSI released
  p_slave_mosi_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (one_wire && !master) |-> !pin_oe[PIN_MOSI]);
endmodule

// File: rtl/sbb_shifter.sv
module sbb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master,
  input  logic         lsb_first,
  input  logic         wr_data,
  input  logic [W-1:0] wdata,
  input  logic         clr_done,
  input  logic         tick,
  input  logic         sck_sync,
  input  logic         ss_sync,
  input  logic         din,
  output logic [W-1:0] sr,
  output logic         out_q,
  output logic         sck_q,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL  = CW'(W);
  localparam logic [CW-1:0] LASTB = CW'(W - 1);

  logic [CW-1:0] bitcnt;
  logic          sck_prev, rise, fall, accept, next_bit;
  logic [W-1:0]  shifted;

  always_comb begin
    if (master) begin
      rise   = tick & busy & ~sck_q;
      fall   = tick & busy & sck_q;
      accept = wr_data & ~busy;
    end else begin
      rise   = ~ss_sync & sck_sync & ~sck_prev;
      fall   = ~ss_sync & ~sck_sync & sck_prev;
      accept = wr_data & (bitcnt == '0);
    end
    shifted  = lsb_first ? {din, sr[W-1:1]} : {sr[W-2:0], din};
    next_bit = lsb_first ? sr[0] : sr[W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      out_q    <= 1'b0;
      sck_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      bitcnt   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_sync;
      if (accept) begin
        sr    <= wdata;
        out_q <= lsb_first ? wdata[0] : wdata[W-1];
        if (master) begin
          busy   <= 1'b1;
          sck_q  <= 1'b0;
          bitcnt <= '0;
        end
      end else if (rise) begin
        sr     <= shifted;
        bitcnt <= bitcnt + 1'b1;
        if (master) sck_q <= 1'b1;
      end else if (fall) begin
        if (master) sck_q <= 1'b0;
        if (bitcnt == FULL) begin
          bitcnt <= '0;
          busy   <= 1'b0;
        end else begin
          out_q <= next_bit;
        end
      end else if (!master && ss_sync) begin
        bitcnt <= '0;
      end

      if (rise && bitcnt == LASTB) done <= 1'b1;
      else if (clr_done)           done <= 1'b0;
    end
  end

  // R13: the transmitted bit holds while SCK is high
  p_out_stable_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (master && busy && sck_q && $past(sck_q)) |-> $stable(out_q));
  // R5: the flag rises only once the full byte has been sampled
  p_done_on_last_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (bitcnt == FULL));
  // R3: SCK rests low outside a transfer
  p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_q);
  // R12: during a transfer the shift register moves only on a sampling edge
  p_busy_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && busy && $past(busy) && !$past(rise)) |-> $stable(sr));
endmodule

// File: rtl/spi_bidir_byte.sv
module spi_bidir_byte import sbb_pkg::*; #(
  parameter int HALF_PERIOD = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              master_sel,
  input  logic              ss_out_en,
  input  logic [NPINS-1:0]  pin_dir,
  input  logic              wait_mode,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              xfer_done
);
  ctrl_t             ctrl;
  logic [NPINS-1:0]  sync1, sync2;
  logic [DATA_W-1:0] sr;
  logic              tick, din, out_q, sck_q, busy, wr_data, data_access;

  assign wr_data     = reg_wr & reg_addr;
  assign data_access = (reg_wr | reg_rd) & reg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (reg_wr && !reg_addr) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  assign reg_rdata = reg_addr ? sr : DATA_W'(ctrl);

  sbb_clkgen #(.HALF(HALF_PERIOD)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .hold (ctrl.halt_in_wait & wait_mode),
    .tick (tick)
  );

  sbb_shifter #(.W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .master   (master_sel),
    .lsb_first(ctrl.lsb_first),
    .wr_data  (wr_data),
    .wdata    (reg_wdata),
    .clr_done (data_access),
    .tick     (tick),
    .sck_sync (sync2[PIN_SCK]),
    .ss_sync  (sync2[PIN_SS]),
    .din      (din),
    .sr       (sr),
    .out_q    (out_q),
    .sck_q    (sck_q),
    .busy     (busy),
    .done     (xfer_done)
  );

  sbb_pinmux u_pinmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .one_wire (ctrl.one_wire),
    .master   (master_sel),
    .ss_out_en(ss_out_en),
    .dir      (pin_dir),
    .pin_raw  (pin_in),
    .pin_sync (sync2),
    .data_bit (out_q),
    .sck_q    (sck_q),
    .busy     (busy),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .din      (din)
  );

  // R2: control bits change only through a control write
  p_ctrl_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(reg_wr) && !$past(reg_addr)) |-> $stable(ctrl));
endmodule

// File: tb/test_spi_bidir_byte.sv
module test_spi_bidir_byte;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, reg_wr, reg_rd, reg_addr, master_sel, ss_out_en, wait_mode;
  logic [7:0] reg_wdata, reg_rdata;
  logic [3:0] pin_dir, pin_in, pin_out, pin_oe;
  logic       xfer_done;

  logic       tb_miso, tb_mosi, tb_sck, tb_ss, use_remote, loop_mosi;
  logic [7:0] remote;
  logic       cmp_on, cmp_master;

  // behavioural reference state
  bit         m_busy, m_sck, m_done;
  int         m_cnt, m_bits;
  logic [7:0] m_tx;
  logic [2:0] m_ctrl;

  int n_vec = 0;
  int n_bad = 0;

  function automatic int wire_idx(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  logic miso_remote;
  always_comb begin
    if (m_bits < 8) miso_remote = remote[wire_idx(m_bits, m_ctrl[2])];
    else            miso_remote = 1'b0;
  end

  assign pin_in[0] = use_remote ? miso_remote : tb_miso;
  assign pin_in[1] = loop_mosi ? pin_out[1] : tb_mosi;
  assign pin_in[2] = tb_sck;
  assign pin_in[3] = tb_ss;

  spi_bidir_byte #(.HALF_PERIOD(HALF), .DATA_W(8)) i_spi_bidir_byte (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_sel(master_sel),
    .ss_out_en(ss_out_en), .pin_dir(pin_dir), .wait_mode(wait_mode), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // reference model, master timing and register side effects
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_sck <= 0; m_done <= 0; m_cnt <= 0; m_bits <= 0;
      m_tx <= '0; m_ctrl <= '0;
    end else begin
      if (reg_wr && !reg_addr) m_ctrl <= reg_wdata[2:0];
      if (reg_wr && reg_addr && master_sel && !m_busy) begin
        m_busy <= 1; m_cnt <= 0; m_sck <= 0; m_bits <= 0; m_tx <= reg_wdata;
      end else if (m_busy && !(m_ctrl[1] && wait_mode)) begin
        if (m_cnt == HALF - 1) begin
          m_cnt <= 0;
          if (!m_sck) begin
            m_sck <= 1; m_bits <= m_bits + 1;
          end else begin
            m_sck <= 0;
            if (m_bits == 8) m_busy <= 0;
          end
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
      if (m_busy && !(m_ctrl[1] && wait_mode) && m_cnt == HALF - 1 && !m_sck && m_bits == 7)
        m_done <= 1;
      else if ((reg_wr || reg_rd) && reg_addr)
        m_done <= 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      logic [3:0] e_oe;
      e_oe[0] = !master_sel & pin_dir[0] & !pin_in[3];
      e_oe[1] = master_sel & pin_dir[1];
      e_oe[2] = master_sel & pin_dir[2];
      e_oe[3] = master_sel & pin_dir[3] & ss_out_en;
      chk("R6/R8/R10 enables", pin_oe, e_oe);
      if (cmp_master) begin
        chk("R3/R11 sck", pin_out[2], m_sck);
        chk("R3 ss", pin_out[3], !m_busy);
        chk("R5 done", xfer_done, m_done);
        if (m_busy) begin
          int k;
          k = m_sck ? m_bits - 1 : m_bits;
          chk("R4/R12/R13 mosi", pin_out[1], m_tx[wire_idx(k, m_ctrl[2])]);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!m_busy) break;
    end
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rb,
                             input logic [7:0] expect_rx, input bit mid_write);
    logic [7:0] v;
    remote = rb;
    wr(1'b1, tx);
    if (mid_write) begin
      repeat (6) @(negedge clk);
      wr(1'b1, ~tx);  // R12: must be dropped
    end
    wait_idle();
    #1 chk("R5 done after byte", xfer_done, 1'b1);
    rd(1'b1, v);
    chk("R4/R7 received byte", v, expect_rx);
    #1 chk("R5 done cleared by read", xfer_done, 1'b0);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rx, input bit one_wire);
    logic [7:0] v;
    logic       lsb;
    lsb = m_ctrl[2];
    wr(1'b1, tx);
    @(negedge clk); tb_ss = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      if (one_wire) begin
        tb_miso = rx[wire_idx(k, lsb)];
        tb_mosi = ~rx[wire_idx(k, lsb)];
      end else begin
        tb_mosi = rx[wire_idx(k, lsb)];
        tb_miso = ~rx[wire_idx(k, lsb)];
      end
      #1;
      if (one_wire) begin
        chk("R9 miso released", pin_oe[0], 1'b0);
        chk("R9 mosi released", pin_oe[1], 1'b0);
      end else begin
        chk("R8 miso driven", pin_oe[0], 1'b1);
        chk("R8/R4 miso bit", pin_out[0], tx[wire_idx(k, lsb)]);
      end
      repeat (3) @(negedge clk);
      tb_sck = 1;
      repeat (6) @(negedge clk);
      tb_sck = 0;
      repeat (6) @(negedge clk);
    end
    #1 chk("R5 slave done", xfer_done, 1'b1);
    @(negedge clk); tb_ss = 1;
    repeat (4) @(negedge clk);
    rd(1'b1, v);
    chk(one_wire ? "R9 slave received" : "R8 slave received", v, rx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       sck_hold;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = '0;
    master_sel = 0; ss_out_en = 0; wait_mode = 0; pin_dir = '0;
    tb_miso = 0; tb_mosi = 0; tb_sck = 0; tb_ss = 1; use_remote = 0; loop_mosi = 0;
    remote = '0; cmp_on = 0; cmp_master = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v);
    chk("R1 control after reset", v, 8'h00);
    chk("R1 done after reset", xfer_done, 1'b0);
    chk("R1 sck after reset", pin_out[2], 1'b0);
    chk("R1 ss after reset", pin_out[3], 1'b1);

    // R2 control register
    wr(1'b0, 8'hFF); rd(1'b0, v); chk("R2 upper bits read 0", v, 8'h07);
    wr(1'b0, 8'h05); rd(1'b0, v); chk("R2 readback", v, 8'h05);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R2 cleared", v, 8'h00);

    cmp_on = 1;
    // R6/R8/R10 enable sweep while idle
    for (int c = 0; c < 128; c++) begin
      @(negedge clk);
      pin_dir = c[3:0]; master_sel = c[4]; ss_out_en = c[5]; tb_ss = c[6];
      #1;
      chk("R10 ss enable", pin_oe[3], c[3] & c[4] & c[5]);
      chk("R8 miso enable", pin_oe[0], c[0] & !c[4] & !c[6]);
    end

    // master, normal wiring
    @(negedge clk);
    master_sel = 1; pin_dir = 4'b1110; ss_out_en = 1; tb_ss = 1;
    use_remote = 1; loop_mosi = 0; cmp_master = 1;
    master_xfer(8'hA5, 8'h3C, 8'h3C, 0);       // R6 R4 MSB first
    wr(1'b0, 8'h04);
    master_xfer(8'h81, 8'hD2, 8'hD2, 0);       // R4 LSB first
    master_xfer(8'h5A, 8'h0F, 8'h0F, 1);       // R12 mid write dropped
    wr(1'b0, 8'h00);
    master_xfer(8'hC3, 8'h96, 8'h96, 1);       // R12 MSB first

    // R11 halt in wait
    wr(1'b0, 8'h02);
    remote = 8'h71;
    wr(1'b1, 8'h4E);
    repeat (5) @(negedge clk);
    wait_mode = 1;
    #1 sck_hold = pin_out[2];
    repeat (20) @(negedge clk);
    #1 chk("R11 sck frozen", pin_out[2], sck_hold);
    @(negedge clk); wait_mode = 0;
    wait_idle();
    rd(1'b1, v); chk("R11 byte after resume", v, 8'h71);
    wr(1'b0, 8'h00);
    @(negedge clk); wait_mode = 1;
    master_xfer(8'h12, 8'hE7, 8'hE7, 0);       // R11 bit clear: runs
    @(negedge clk); wait_mode = 0;

    // R7 single-wire master: loop MOSI, MISO carries other data
    wr(1'b0, 8'h01);
    @(negedge clk); loop_mosi = 1;
    master_xfer(8'h6B, 8'h00, 8'h6B, 0);
    wr(1'b0, 8'h05);
    master_xfer(8'hB4, 8'hFF, 8'hB4, 0);

    // slave modes (model does not track slave timing)
    cmp_master = 0;
    @(negedge clk);
    loop_mosi = 0; use_remote = 0; master_sel = 0; pin_dir = 4'b0001; tb_ss = 1;
    wr(1'b0, 8'h00);
    slave_xfer(8'hA3, 8'h5C, 0);               // R8 MSB first
    wr(1'b0, 8'h04);
    slave_xfer(8'h1E, 8'hC9, 0);               // R8 R4 LSB first
    @(negedge clk); pin_dir = 4'b0000;
    wr(1'b0, 8'h01);
    slave_xfer(8'h00, 8'h8D, 1);               // R9 single wire

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule